// File: doc/BRIEF.md
# Receive Clock Frequency Range Detector

This block decides whether a receive clock-recovery loop should follow the incoming data stream or fall back to the local reference clock. It counts cycles of the recovered receive clock over a fixed window of reference clock cycles. It then takes the absolute difference between that count and the window length, and compares the result against a threshold that depends on the source currently being followed. Leaving the data stream needs a large deviation, while returning to it needs a small one. Deviations between the two thresholds change nothing, which gives the switching its hysteresis.

The two clocks are unrelated. The receive side runs a free-running cycle counter. At the end of every window the reference side flips a request toggle. The receive side answers by freezing its counter into a snapshot register and flipping an acknowledge toggle. The reference side reads the snapshot only after the acknowledge has been synchronized, and it subtracts successive snapshots. The fixed synchronizer latency therefore cancels out, leaving an uncertainty of about one count.

If the receive clock stops, a request is still unanswered when the next window ends. The block treats that as out of range.

Top module: `freq_range_det`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `trk_ref_o` is 1 and `link_ok_o` is 0 (follow the reference).
- R2: A measurement is the number of `rx_clk` cycles between two consecutive window ends, where a window is 2^WIN_LOG2 `ref_clk` cycles. The deviation is |count − 2^WIN_LOG2|. The first answered window after reset, or after a missed measurement, only sets the baseline and makes no decision.
- R3: While following the data stream (`link_ok_o`=1), a deviation of LOSS_DIFF or more switches the block to the reference (`trk_ref_o`=1, `link_ok_o`=0).
- R4: While following the data stream, a deviation below LOSS_DIFF leaves the block on the data stream.
- R5: While following the reference, a deviation of LOCK_DIFF or less switches the block to the data stream (`link_ok_o`=1).
- R6: While following the reference, a deviation above LOCK_DIFF leaves the block on the reference.
- R7: A receive clock that is too slow is judged exactly like one that is too fast by the same number of counts.
- R8: If a window ends while the previous request is still unanswered, the block switches to the reference. Once the receive clock runs again, it returns to the data stream through the normal rules.
- R9: `link_ok_o` is always the inverse of `trk_ref_o`.
- R10: The outputs change only in the cycle after a completed measurement or a missed one, and never in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local reference character clock; sets the measurement window |
| rx_clk | input | 1 | Recovered receive clock, asynchronous to `ref_clk` |
| rst | input | 1 | Active-high reset, synchronous to `ref_clk`; synchronized internally into the `rx_clk` domain |
| trk_ref_o | output | 1 | 1: the loop should follow the local reference; 0: the loop should follow the data stream |
| link_ok_o | output | 1 | In-range status for the link-fault logic; 1 while following the data stream |

## Verification
The bench builds the block with a window of 2^10 reference cycles, LOSS_DIFF = 6 and LOCK_DIFF = 2. The shorter window makes each decision about a thousand cycles, so every transition, both hold bands, both signs of deviation and a stalled receive clock fit in one run. The dead band of three to five counts is wider than the one-count uncertainty of the crossing. Receive clock offsets of ±4 counts therefore land in the band in every window, and offsets of 0, ±1 and ±10 land clearly on one side of a threshold. This makes the hysteresis checks deterministic.

// File: rtl/freq_rd_pkg.sv
package freq_rd_pkg;

    // Source followed by the receive loop.
    typedef enum logic {
        TRK_REF_SRC  = 1'b0,
        TRK_DATA_SRC = 1'b1
    } trk_src_e;

    // Kind of event delivered by the measurement side once per window.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_MEAS = 2'd1,
        EV_MISS = 2'd2
    } meas_ev_e;

    // One measurement verdict: far = deviation at or above the loss limit,
    // near = deviation at or below the lock limit.
    typedef struct packed {
        meas_ev_e ev;
        logic     far;
        logic     near;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{ev: EV_NONE, far: 1'b0, near: 1'b0};

    // Next followed source; the threshold that matters depends on the current one.
    function automatic trk_src_e next_src(input trk_src_e cur, input verdict_t v);
        trk_src_e nxt;
        nxt = cur;
        if (v.ev == EV_MISS) begin
            nxt = TRK_REF_SRC;
        end else if (v.ev == EV_MEAS) begin
            if (cur == TRK_DATA_SRC && v.far) begin
                nxt = TRK_REF_SRC;
            end else if (cur == TRK_REF_SRC && v.near) begin
                nxt = TRK_DATA_SRC;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/frd_sync.sv
module frd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/frd_rx_sampler.sv
module frd_rx_sampler #(
    parameter int CNT_W  = 14,
    parameter int STAGES = 2
) (
    input  logic             rx_clk,
    input  logic             rst_async,
    input  logic             req_tgl_i,
    output logic [CNT_W-1:0] snap_o,
    output logic             ack_tgl_o
);
    logic             rx_rst;
    logic             req_s;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic             req_seen_q;
    logic             ack_q;

    // Reset brought into the receive domain (the chain itself has no reset).
    frd_sync #(.W(1), .STAGES(STAGES)) u_rst_sync (
        .clk (rx_clk),
        .rst (1'b0),
        .d   (rst_async),
        .q   (rx_rst)
    );

    frd_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk (rx_clk),
        .rst (rx_rst),
        .d   (req_tgl_i),
        .q   (req_s)
    );

    always_ff @(posedge rx_clk) begin
        if (rx_rst) begin
            cnt_q      <= '0;
            snap_q     <= '0;
            req_seen_q <= 1'b0;
            ack_q      <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (req_s != req_seen_q) begin
                req_seen_q <= req_s;
                snap_q     <= cnt_q;
                ack_q      <= ~ack_q;
            end
        end
    end

    assign snap_o    = snap_q;
    assign ack_tgl_o = ack_q;
endmodule

// File: rtl/frd_ref_collector.sv
module frd_ref_collector
    import freq_rd_pkg::*;
#(
    parameter int WIN_LOG2  = 12,
    parameter int CNT_W     = 14,
    parameter int STAGES    = 2,
    parameter int LOSS_DIFF = 8,
    parameter int LOCK_DIFF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_tgl_i,
    input  logic [CNT_W-1:0] snap_i,
    output logic             req_tgl_o,
    output verdict_t         verdict_o
);
    localparam logic [CNT_W-1:0] WIN_CNT = CNT_W'(1) << WIN_LOG2;
    localparam logic [CNT_W-1:0] LOSS_T  = CNT_W'(LOSS_DIFF);
    localparam logic [CNT_W-1:0] LOCK_T  = CNT_W'(LOCK_DIFF);

    logic [WIN_LOG2-1:0] win_q;
    logic                tick;
    logic                ack_s;
    logic                ack_seen_q;
    logic                req_q;
    logic                have_base_q;
    logic [CNT_W-1:0]    base_q;
    logic                ack_new;
    logic                outstanding;
    logic [CNT_W-1:0]    delta;
    logic [CNT_W-1:0]    dev;
    verdict_t            verdict_q;

    frd_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl_i),
        .q   (ack_s)
    );

    always_comb begin
        tick        = &win_q;
        ack_new     = (ack_s != ack_seen_q);
        outstanding = (req_q != ack_s);
        delta       = snap_i - base_q;
        dev         = (delta >= WIN_CNT) ? (delta - WIN_CNT) : (WIN_CNT - delta);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q       <= '0;
            req_q       <= 1'b0;
            ack_seen_q  <= 1'b0;
            have_base_q <= 1'b0;
            base_q      <= '0;
            verdict_q   <= VERDICT_IDLE;
        end else begin
            win_q     <= win_q + 1'b1;
            verdict_q <= VERDICT_IDLE;
            if (ack_new) begin
                ack_seen_q  <= ack_s;
                base_q      <= snap_i;
                have_base_q <= 1'b1;
                if (have_base_q) begin
                    verdict_q <= '{ev: EV_MEAS, far: (dev >= LOSS_T), near: (dev <= LOCK_T)};
                end
            end
            if (tick) begin
                if (outstanding) begin
                    verdict_q   <= '{ev: EV_MISS, far: 1'b0, near: 1'b0};
                    have_base_q <= 1'b0;
                end else begin
                    req_q <= ~req_q;
                end
            end
        end
    end

    assign req_tgl_o = req_q;
    assign verdict_o = verdict_q;
endmodule

// File: rtl/frd_track_fsm.sv
module frd_track_fsm
    import freq_rd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict_i,
    output trk_src_e src_o
);
    trk_src_e src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= TRK_REF_SRC;
        end else begin
            src_q <= next_src(src_q, verdict_i);
        end
    end

    assign src_o = src_q;
endmodule

// File: rtl/freq_range_det.sv
module freq_range_det
    import freq_rd_pkg::*;
#(
    parameter int WIN_LOG2    = 12,
    parameter int LOSS_DIFF   = 8,
    parameter int LOCK_DIFF   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rx_clk,
    input  logic rst,
    output logic trk_ref_o,
    output logic link_ok_o
);
    localparam int CNT_W = WIN_LOG2 + 2;

    logic             req_tgl;
    logic             ack_tgl;
    logic [CNT_W-1:0] snap;
    verdict_t         verdict;
    trk_src_e         src;

    frd_rx_sampler #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_rx (
        .rx_clk    (rx_clk),
        .rst_async (rst),
        .req_tgl_i (req_tgl),
        .snap_o    (snap),
        .ack_tgl_o (ack_tgl)
    );

    frd_ref_collector #(
        .WIN_LOG2  (WIN_LOG2),
        .CNT_W     (CNT_W),
        .STAGES    (SYNC_STAGES),
        .LOSS_DIFF (LOSS_DIFF),
        .LOCK_DIFF (LOCK_DIFF)
    ) u_col (
        .clk       (ref_clk),
        .rst       (rst),
        .ack_tgl_i (ack_tgl),
        .snap_i    (snap),
        .req_tgl_o (req_tgl),
        .verdict_o (verdict)
    );

    frd_track_fsm u_fsm (
        .clk       (ref_clk),
        .rst       (rst),
        .verdict_i (verdict),
        .src_o     (src)
    );

    assign trk_ref_o = (src == TRK_REF_SRC);
    assign link_ok_o = (src == TRK_DATA_SRC);
endmodule

// File: rtl/freq_range_det_chk.sv
module freq_range_det_chk
    import freq_rd_pkg::*;
(
    input logic     ref_clk,
    input logic     rst,
    input logic     trk_ref,
    input logic     link_ok,
    input verdict_t verdict
);
    p_reset_state_r1: assert property (@(posedge ref_clk)
        rst |=> (trk_ref && !link_ok));

    p_quiet_between_r10: assert property (@(posedge ref_clk) disable iff (rst)
        (verdict.ev == EV_NONE) |=> ($stable(link_ok) && $stable(trk_ref)));

    p_loss_leaves_r3: assert property (@(posedge ref_clk) disable iff (rst)
        (verdict.ev == EV_MEAS && verdict.far && link_ok) |=> trk_ref);

    p_small_keeps_r4: assert property (@(posedge ref_clk) disable iff (rst)
        (verdict.ev == EV_MEAS && !verdict.far && link_ok) |=> link_ok);

    p_lock_enters_r5: assert property (@(posedge ref_clk) disable iff (rst)
        (verdict.ev == EV_MEAS && verdict.near && trk_ref) |=> link_ok);

    p_large_stays_r6: assert property (@(posedge ref_clk) disable iff (rst)
        (verdict.ev == EV_MEAS && !verdict.near && trk_ref) |=> trk_ref);

    p_miss_falls_back_r8: assert property (@(posedge ref_clk) disable iff (rst)
        (verdict.ev == EV_MISS) |=> trk_ref);

    p_limits_disjoint_r2: assert property (@(posedge ref_clk) disable iff (rst)
        (verdict.ev == EV_MEAS) |-> !(verdict.near && verdict.far));
endmodule

bind freq_range_det freq_range_det_chk u_chk (
    .ref_clk (ref_clk),
    .rst     (rst),
    .trk_ref (trk_ref_o),
    .link_ok (link_ok_o),
    .verdict (verdict)
);

// File: tb/freq_range_det_tb_top.sv
`timescale 1ns/1ps
module freq_range_det_tb_top;
    localparam int  WL     = 10;
    localparam int  WIN    = 1 << WL;
    localparam int  LOSS   = 6;
    localparam int  LOCK   = 2;
    localparam real WIN_R  = 1024.0;
    localparam int  STEP_N = 9;

    // Receive clock offset in counts per window, expected link_ok_o after settling.
    localparam int    STEP_OFS  [STEP_N] = '{4, 10, 4, 1, -10, -4, -1, -4, 0};
    localparam bit    STEP_LINK [STEP_N] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam string STEP_REQ  [STEP_N] = '{"R4", "R3 R7 fast", "R6", "R5", "R3 R7 slow",
                                             "R6", "R5", "R4", "R4"};

    logic    ref_clk = 1'b0;
    logic    rx_clk  = 1'b0;
    logic    rst     = 1'b1;
    logic    rx_run  = 1'b1;
    realtime rx_half = 2.5;
    logic    trk_ref_o;
    logic    link_ok_o;
    int      checks  = 0;
    int      errors  = 0;
    int      wd      = 0;
    bit      done    = 1'b0;

    freq_range_det #(
        .WIN_LOG2    (WL),
        .LOSS_DIFF   (LOSS),
        .LOCK_DIFF   (LOCK),
        .SYNC_STAGES (2)
    ) dut_i (
        .ref_clk   (ref_clk),
        .rx_clk    (rx_clk),
        .rst       (rst),
        .trk_ref_o (trk_ref_o),
        .link_ok_o (link_ok_o)
    );

    always #2.5 ref_clk = ~ref_clk;

    initial begin
        forever begin
            #(rx_half);
            if (rx_run) rx_clk = ~rx_clk;
        end
    end

    always @(posedge ref_clk) begin
        wd++;
        if (wd > 190000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog (all requirements): got cycle %0d expected below 190000", wd);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_rx(input int ofs);
        rx_half = 2.5 * WIN_R / (WIN_R + real'(ofs));
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic check(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // R9: both outputs checked together, always complementary.
    task automatic check_state(input string req, input logic exp_link);
        check(req, "link_ok_o", link_ok_o, exp_link);
        check({req, " R9"}, "trk_ref_o", trk_ref_o, !exp_link);
    endtask

    initial begin
        set_rx(0);
        wait_cycles(20);
        check_state("R1 in reset", 1'b0);
        rst = 1'b0;
        wait_cycles(1);
        check_state("R1 after release", 1'b0);

        // R2: first answered window only sets the baseline.
        wait_cycles(WIN + WIN / 2 - 1);
        check_state("R2 no decision after first window", 1'b0);
        wait_cycles(WIN);
        check_state("R2 R5 first decision", 1'b1);

        for (int s = 0; s < STEP_N; s++) begin
            set_rx(STEP_OFS[s]);
            wait_cycles(4 * WIN);
            check_state(STEP_REQ[s], STEP_LINK[s]);
        end

        // R8: stalled receive clock, then recovery.
        rx_run = 1'b0;
        wait_cycles(3 * WIN);
        check_state("R8 stalled clock", 1'b0);
        wait_cycles(WIN);
        check_state("R8 still stalled", 1'b0);
        set_rx(0);
        rx_run = 1'b1;
        wait_cycles(WIN / 2);
        check_state("R2 R8 baseline only after restart", 1'b0);
        wait_cycles(5 * WIN);
        check_state("R8 recovered", 1'b1);

        // R1: reset in the middle of operation.
        rst = 1'b1;
        wait_cycles(10);
        check_state("R1 mid-run reset", 1'b0);
        rst = 1'b0;
        wait_cycles(1);
        check_state("R1 mid-run release", 1'b0);
        wait_cycles(3 * WIN);
        check_state("R5 after mid-run reset", 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule